// File: doc/BRIEF.md
# Ethernet receive frame admission filter

This block sits on an Ethernet receive path behind the byte deserializer and decides, for every frame, whether it is kept or dropped. It follows a byte stream marked with valid, start-of-frame and end-of-frame strobes. From that stream it picks up the destination address, the type/length field and the MAC control opcode, and it counts the bytes of the frame. On the last byte it also samples four status lines from the receive logic: receive error, CRC failure, trailing (dribble) bits and collision.

An 8-bit policy register, written through a simple write strobe, selects which frame classes and error conditions are allowed through. One clock after the last byte the block presents a single decision. The decision is an accept flag plus a mask of reject reasons, and every reason that applies is set. Buffering the frame, computing the CRC and acting on pause frames belong to other blocks.

Top module: `rxf_filter`

## Requirements
- R1: After reset the policy register holds 0x00, so every reject rule is active, and `dec_valid`, `dec_accept` and `dec_reason` are all zero.
- R2: A frame of at least 6 bytes whose first six bytes are all 0xFF is a broadcast frame. It sets reason bit 0 when policy bit 0 is 0.
- R3: A frame with `rx_mii_err` high on its last byte sets reason bit 1 when policy bit 1 is 0.
- R4: A frame with `rx_dribble` high sets reason bit 2 when policy bit 2 is 0. This applies only if `rx_collision` is low and the frame has 64 bytes or more (FCS included). A shorter frame is a runt and never sets bit 2.
- R5: A frame with `rx_crc_err` or `rx_mii_err` high sets reason bit 3 when policy bit 3 is 0.
- R6: When the big-endian value in bytes 12–13 is 1500 or less, it is a length. With payload = byte count − 18, the frame matches when payload equals that length. If the length is under 46, the frame matches only when payload is 46. A frame under 18 bytes never matches. A mismatch sets reason bit 4 when policy bit 4 is 0. Values above 1500 always match.
- R7: A frame whose bytes 12–13 hold 0x8808 is a control frame. It sets reason bit 5 when policy bit 5 is 0.
- R8: A control frame whose bytes 14–15 are not 0x0001 (a non-pause frame) sets reason bit 6 when policy bit 6 is 0. A pause frame never sets bit 6.
- R9: When the last byte (`rx_valid` and `rx_eof`) is taken at a clock edge, `dec_valid` is high for exactly the following cycle. `dec_valid` is high in no other cycle.
- R10: `dec_accept` is 1 exactly when `dec_valid` is 1 and `dec_reason` is all zeros. All reasons that apply are reported together. With policy bits 6..0 all set, every frame is accepted.
- R11: A policy write applies to frames whose first byte arrives after the write. A write in the same cycle as a start-of-frame byte, or during a frame, does not change the decision for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_wr | input | 1 | Policy register write strobe |
| pol_wdata | input | 8 | Policy value to write (bit 7 unused) |
| rx_valid | input | 1 | A byte is present on `rx_data` |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_mii_err | input | 1 | Receive error seen, sampled with the last byte |
| rx_crc_err | input | 1 | CRC check failed, sampled with the last byte |
| rx_dribble | input | 1 | Trailing non-byte bits, sampled with the last byte |
| rx_collision | input | 1 | Collision seen, sampled with the last byte |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 7 | Reject reason mask, bit k follows policy bit k |

## Verification
Two events can land in the same cycle: a policy write and the start of a frame. The write can also fall in the middle of the frame, while the header fields are being captured. The bench drives writes on the start-of-frame byte and on random mid-frame bytes. It judges each decision against a model that uses the policy value that held before that frame began. It also checks that several reasons raised by a single frame all appear together, with multiple error lines and header classes combined on purpose.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int NUM_RSN     = 7;
  localparam int RSN_BCAST   = 0;
  localparam int RSN_RXERR   = 1;
  localparam int RSN_DRIBBLE = 2;
  localparam int RSN_CRC     = 3;
  localparam int RSN_LENGTH  = 4;
  localparam int RSN_CTRL    = 5;
  localparam int RSN_NPAUSE  = 6;

  localparam int          HDR_BYTES   = 14;
  localparam int          FCS_BYTES   = 4;
  localparam int          MAX_LEN     = 1500;
  localparam int          MIN_PAYLOAD = 46;
  localparam logic [15:0] CTRL_TYPE   = 16'h8808;
  localparam logic [15:0] PAUSE_OP    = 16'h0001;

  // Length field versus bytes received; padded frames accept short lengths.
  function automatic logic len_match(input logic [15:0] tl, input int unsigned cnt);
    int pay;
    if (int'(tl) > MAX_LEN) return 1'b1;
    if (cnt < HDR_BYTES + FCS_BYTES) return 1'b0;
    pay = int'(cnt) - (HDR_BYTES + FCS_BYTES);
    if (int'(tl) < MIN_PAYLOAD) return pay == MIN_PAYLOAD;
    return pay == int'(tl);
  endfunction

  // One bit per policy bit: condition present and policy bit clear.
  function automatic logic [NUM_RSN-1:0] reason_mask(
    input logic [7:0]  pol,
    input logic        bcast,
    input logic [15:0] tl,
    input logic [15:0] op,
    input int unsigned cnt,
    input logic        runt,
    input logic        rxerr,
    input logic        crcerr,
    input logic        dribble,
    input logic        coll);
    logic [NUM_RSN-1:0] m;
    logic ctl;
    ctl = (tl == CTRL_TYPE);
    m = '0;
    m[RSN_BCAST]   = bcast & ~pol[RSN_BCAST];
    m[RSN_RXERR]   = rxerr & ~pol[RSN_RXERR];
    m[RSN_DRIBBLE] = dribble & ~coll & ~runt & ~pol[RSN_DRIBBLE];
    m[RSN_CRC]     = (crcerr | rxerr) & ~pol[RSN_CRC];
    m[RSN_LENGTH]  = ~len_match(tl, cnt) & ~pol[RSN_LENGTH];
    m[RSN_CTRL]    = ctl & ~pol[RSN_CTRL];
    m[RSN_NPAUSE]  = ctl & (op != PAUSE_OP) & ~pol[RSN_NPAUSE];
    return m;
  endfunction

endpackage

// File: rtl/rxf_policy.sv
module rxf_policy #(
  parameter int POL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [POL_W-1:0] wdata,
  input  logic             sof_v,
  output logic [POL_W-1:0] pol_act,
  output logic [POL_W-1:0] pol_eff
);
  logic [POL_W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pol_act  <= '0;
    end else begin
      if (wr)    shadow_q <= wdata;
      if (sof_v) pol_act  <= shadow_q;
    end
  end

  // A single-byte frame is judged with the value latched at its own start.
  assign pol_eff = sof_v ? shadow_q : pol_act;
endmodule

// File: rtl/rxf_hdr_parse.sv
module rxf_hdr_parse #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             sof,
  input  logic [7:0]       data,
  output logic [CNT_W-1:0] cnt_n,
  output logic             bc_n,
  output logic [15:0]      tl_n,
  output logic [15:0]      op_n
);
  localparam logic [CNT_W-1:0] DA_END = CNT_W'(6);
  localparam logic [CNT_W-1:0] TL_HI  = CNT_W'(12);
  localparam logic [CNT_W-1:0] TL_LO  = CNT_W'(13);
  localparam logic [CNT_W-1:0] OP_HI  = CNT_W'(14);
  localparam logic [CNT_W-1:0] OP_LO  = CNT_W'(15);
  localparam logic [CNT_W-1:0] CNT_MX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_b;
  logic             bc_q, bc_b;
  logic [15:0]      tl_q, tl_b, op_q, op_b;

  always_comb begin
    cnt_b = sof ? '0 : cnt_q;
    bc_b  = sof ? 1'b1 : bc_q;
    tl_b  = sof ? '0 : tl_q;
    op_b  = sof ? '0 : op_q;
    cnt_n = cnt_b;
    bc_n  = bc_b;
    tl_n  = tl_b;
    op_n  = op_b;
    if (valid) begin
      if (cnt_b < DA_END) bc_n = bc_b & (data == 8'hFF);
      if (cnt_b == TL_HI) tl_n[15:8] = data;
      if (cnt_b == TL_LO) tl_n[7:0]  = data;
      if (cnt_b == OP_HI) op_n[15:8] = data;
      if (cnt_b == OP_LO) op_n[7:0]  = data;
      if (cnt_b != CNT_MX) cnt_n = cnt_b + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bc_q  <= 1'b1;
      tl_q  <= '0;
      op_q  <= '0;
    end else if (valid) begin
      cnt_q <= cnt_n;
      bc_q  <= bc_n;
      tl_q  <= tl_n;
      op_q  <= op_n;
    end
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eof_v,
  input  logic [7:0]         pol,
  input  logic               bcast,
  input  logic [15:0]        tl,
  input  logic [15:0]        op,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               runt,
  input  logic               rxerr,
  input  logic               crcerr,
  input  logic               dribble,
  input  logic               coll,
  output logic               dec_valid,
  output logic               dec_accept,
  output logic [NUM_RSN-1:0] dec_reason
);
  logic [NUM_RSN-1:0] mask_w;

  assign mask_w = reason_mask(pol, bcast, tl, op, 32'(cnt), runt,
                              rxerr, crcerr, dribble, coll);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= '0;
    end else begin
      dec_valid  <= eof_v;
      dec_accept <= eof_v & (mask_w == '0);
      dec_reason <= eof_v ? mask_w : '0;
    end
  end
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter
  import rxf_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RUNT_MIN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pol_wr,
  input  logic [7:0]         pol_wdata,
  input  logic               rx_valid,
  input  logic               rx_sof,
  input  logic               rx_eof,
  input  logic [7:0]         rx_data,
  input  logic               rx_mii_err,
  input  logic               rx_crc_err,
  input  logic               rx_dribble,
  input  logic               rx_collision,
  output logic               dec_valid,
  output logic               dec_accept,
  output logic [NUM_RSN-1:0] dec_reason
);
  localparam logic [CNT_W-1:0] RUNT_LIM = CNT_W'(RUNT_MIN);
  localparam logic [CNT_W-1:0] DA_LEN   = CNT_W'(6);

  logic             sof_v, eof_v;
  logic [7:0]       pol_act, pol_eff;
  logic [CNT_W-1:0] cnt_w;
  logic             bc_raw, bcast_w, runt_w;
  logic [15:0]      tl_w, op_w;

  assign sof_v   = rx_valid & rx_sof;
  assign eof_v   = rx_valid & rx_eof;

  rxf_policy #(.POL_W(8)) u_policy (
    .clk(clk), .rst_n(rst_n), .wr(pol_wr), .wdata(pol_wdata),
    .sof_v(sof_v), .pol_act(pol_act), .pol_eff(pol_eff)
  );

  rxf_hdr_parse #(.CNT_W(CNT_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .valid(rx_valid), .sof(sof_v), .data(rx_data),
    .cnt_n(cnt_w), .bc_n(bc_raw), .tl_n(tl_w), .op_n(op_w)
  );

  assign bcast_w = bc_raw & (cnt_w >= DA_LEN);
  assign runt_w  = cnt_w < RUNT_LIM;

  rxf_decide #(.CNT_W(CNT_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .eof_v(eof_v), .pol(pol_eff),
    .bcast(bcast_w), .tl(tl_w), .op(op_w), .cnt(cnt_w), .runt(runt_w),
    .rxerr(rx_mii_err), .crcerr(rx_crc_err), .dribble(rx_dribble),
    .coll(rx_collision),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
  );
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sof_v,
  input logic       eof_v,
  input logic [7:0] pol_act,
  input logic [7:0] pol_eff,
  input logic       bcast_w,
  input logic       runt_w,
  input logic       rx_collision,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic [6:0] dec_reason
);
  a_r9_dec_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
    eof_v |=> dec_valid);
  a_r9_no_spurious_dec: assert property (@(posedge clk) disable iff (!rst_n)
    !eof_v |=> !dec_valid);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && dec_reason == 7'd0));
  a_r10_all_open_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_v && pol_eff[6:0] == 7'h7F) |=> dec_accept);
  a_r4_dribble_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_v && (rx_collision || runt_w)) |=> !dec_reason[2]);
  a_r2_bcast_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_v && bcast_w && !pol_eff[0]) |=> dec_reason[0]);
  a_r11_policy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_v |=> $stable(pol_act));
endmodule

bind rxf_filter rxf_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof_v(sof_v), .eof_v(eof_v),
  .pol_act(pol_act), .pol_eff(pol_eff), .bcast_w(bcast_w), .runt_w(runt_w),
  .rx_collision(rx_collision), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .dec_reason(dec_reason)
);

// File: tb/test_rxf_filter.sv
module test_rxf_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, pol_wr, rx_valid, rx_sof, rx_eof;
  logic [7:0] pol_wdata, rx_data;
  logic       rx_mii_err, rx_crc_err, rx_dribble, rx_collision;
  logic       dec_valid, dec_accept;
  logic [6:0] dec_reason;

  rxf_filter i_rxf_filter (
    .clk(clk), .rst_n(rst_n), .pol_wr(pol_wr), .pol_wdata(pol_wdata),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .rx_mii_err(rx_mii_err), .rx_crc_err(rx_crc_err), .rx_dribble(rx_dribble),
    .rx_collision(rx_collision), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_reason(dec_reason)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] fb [0:255];
  logic [7:0] sh_pol = 8'h00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bench restatement of the admission rules.
  function automatic logic [6:0] exp_mask(input logic [7:0] pol, input int n,
      input logic mii, input logic crc, input logic drb, input logic col);
    logic [6:0] m;
    logic bc, ctl, lok;
    int tl, op, pay;
    bc = (n >= 6);
    for (int i = 0; i < 6; i++) if (i < n && fb[i] != 8'hFF) bc = 1'b0;
    tl = (n >= 14) ? {fb[12], fb[13]} : (n == 13) ? {fb[12], 8'h00} : 0;
    op = (n >= 16) ? {fb[14], fb[15]} : (n == 15) ? {fb[14], 8'h00} : 0;
    ctl = (tl == 'h8808);
    pay = n - 18;
    if (tl > 1500)    lok = 1'b1;
    else if (n < 18)  lok = 1'b0;
    else if (tl < 46) lok = (pay == 46);
    else              lok = (pay == tl);
    m[0] = bc & ~pol[0];
    m[1] = mii & ~pol[1];
    m[2] = drb & ~col & (n >= 64) & ~pol[2];
    m[3] = (crc | mii) & ~pol[3];
    m[4] = ~lok & ~pol[4];
    m[5] = ctl & ~pol[5];
    m[6] = ctl & (op != 1) & ~pol[6];
    return m;
  endfunction

  task automatic build(input int n, input logic bc, input logic [15:0] tl, input logic [15:0] op);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
    if (fb[0] == 8'hFF) fb[0] = 8'h02;
    if (bc) for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
    fb[12] = tl[15:8]; fb[13] = tl[7:0];
    fb[14] = op[15:8]; fb[15] = op[7:0];
  endtask

  task automatic write_pol(input logic [7:0] v);
    @(negedge clk);
    pol_wr = 1'b1; pol_wdata = v;
    @(negedge clk);
    pol_wr = 1'b0;
    sh_pol = v;
  endtask

  task automatic send(input string tag, input int n, input logic mii, input logic crc,
                      input logic drb, input logic col, input int wr_at, input logic [7:0] wv);
    logic [7:0] pol_f;
    logic [6:0] em;
    pol_f = sh_pol;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = fb[i];
      rx_mii_err = mii; rx_crc_err = crc; rx_dribble = drb; rx_collision = col;
      pol_wr = (i == wr_at); pol_wdata = wv;
    end
    if (wr_at >= 0 && wr_at < n) sh_pol = wv;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; pol_wr = 1'b0;
    rx_mii_err = 1'b0; rx_crc_err = 1'b0; rx_dribble = 1'b0; rx_collision = 1'b0;
    em = exp_mask(pol_f, n, mii, crc, drb, col);
    chk({"R9 dec_valid high, ", tag}, 32'(dec_valid), 32'd1);
    chk({tag, " reason mask"}, 32'(dec_reason), 32'(em));
    chk({"R10 accept, ", tag}, 32'(dec_accept), 32'(em == 7'd0));
    @(negedge clk);
    chk("R9 dec_valid single cycle", 32'(dec_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; pol_wr = 1'b0; pol_wdata = 8'h00;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
    rx_mii_err = 1'b0; rx_crc_err = 1'b0; rx_dribble = 1'b0; rx_collision = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dec_valid in reset", 32'(dec_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dec_valid after reset", 32'(dec_valid), 32'd0);
    chk("R1 dec_accept after reset", 32'(dec_accept), 32'd0);
    chk("R1 dec_reason after reset", 32'(dec_reason), 32'd0);

    // R1: reset policy rejects errors; clean frame accepted
    build(64, 1'b0, 16'h0800, 16'h0000); send("R1 clean", 64, 0, 0, 0, 0, -1, 0);
    build(64, 1'b0, 16'h0800, 16'h0000); send("R3 R5 rx error", 64, 1, 0, 0, 0, -1, 0);
    build(64, 1'b0, 16'h0800, 16'h0000); send("R5 crc", 64, 0, 1, 0, 0, -1, 0);
    build(64, 1'b1, 16'h0800, 16'h0000); send("R2 bcast", 64, 0, 0, 0, 0, -1, 0);
    build(5, 1'b1, 16'h0800, 16'h0000);  send("R2 short bcast", 5, 0, 0, 0, 0, -1, 0);
    build(64, 1'b0, 16'h0800, 16'h0000); send("R4 dribble", 64, 0, 0, 1, 0, -1, 0);
    build(64, 1'b0, 16'h0800, 16'h0000); send("R4 dribble collision", 64, 0, 0, 1, 1, -1, 0);
    build(63, 1'b0, 16'h0800, 16'h0000); send("R4 dribble runt", 63, 0, 0, 1, 0, -1, 0);
    build(64, 1'b0, 16'd20, 16'h0000);   send("R6 padded match", 64, 0, 0, 0, 0, -1, 0);
    build(68, 1'b0, 16'd50, 16'h0000);   send("R6 exact match", 68, 0, 0, 0, 0, -1, 0);
    build(70, 1'b0, 16'd50, 16'h0000);   send("R6 mismatch", 70, 0, 0, 0, 0, -1, 0);
    build(66, 1'b0, 16'd46, 16'h0000);   send("R6 short payload", 66, 0, 0, 0, 0, -1, 0);
    build(64, 1'b0, 16'h8808, 16'h0001); send("R7 pause blocked", 64, 0, 0, 0, 0, -1, 0);
    write_pol(8'h01);
    build(64, 1'b1, 16'h0800, 16'h0000); send("R2 bcast allowed", 64, 0, 0, 0, 0, -1, 0);
    write_pol(8'h20);
    build(64, 1'b0, 16'h8808, 16'h0001); send("R8 pause allowed", 64, 0, 0, 0, 0, -1, 0);
    build(64, 1'b0, 16'h8808, 16'h0003); send("R8 nonpause blocked", 64, 0, 0, 0, 0, -1, 0);
    write_pol(8'h60);
    build(64, 1'b0, 16'h8808, 16'h0003); send("R8 nonpause allowed", 64, 0, 0, 0, 0, -1, 0);
    write_pol(8'h02);
    build(64, 1'b0, 16'h0800, 16'h0000); send("R3 R5 rx error partial", 64, 1, 0, 0, 0, -1, 0);
    write_pol(8'h7F);
    build(40, 1'b1, 16'h8808, 16'h0009); send("R10 all open", 40, 1, 1, 1, 0, -1, 0);
    // R11: write on the first byte and mid-frame leave the current frame alone
    build(64, 1'b1, 16'h0800, 16'h0000); send("R11 write at sof", 64, 1, 1, 0, 0, 0, 8'h00);
    build(64, 1'b1, 16'h0800, 16'h0000); send("R11 new policy used", 64, 1, 1, 0, 0, 20, 8'h7F);
    build(64, 1'b1, 16'h0800, 16'h0000); send("R11 mid write applied", 64, 1, 1, 0, 0, -1, 0);
    build(1, 1'b0, 16'h0000, 16'h0000);  send("R6 single byte", 1, 0, 0, 0, 0, -1, 0);

    for (int k = 0; k < 300; k++) begin
      int n, mode, wa;
      logic [15:0] tl, op;
      logic bc;
      n = 1 + int'($urandom % 130);
      mode = int'($urandom % 6);
      bc = ($urandom % 4 == 0);
      tl = 16'($urandom); op = 16'($urandom);
      if (mode == 0) begin tl = 16'h8808; op = 16'h0001; end
      if (mode == 1) tl = 16'h8808;
      if (mode == 2) begin n = 64 + int'($urandom % 60); tl = 16'(n - 18); end
      if (mode == 3) begin n = 64; tl = 16'($urandom % 47); end
      if (mode == 4) tl = 16'($urandom % 1600);
      build(n, bc, tl, op);
      if ($urandom % 5 == 0) write_pol(8'($urandom));
      wa = ($urandom % 6 == 0) ? int'($urandom % n) : -1;
      send("R10 random", n, ($urandom % 5 == 0), ($urandom % 5 == 0),
           ($urandom % 3 == 0), ($urandom % 4 == 0), wa, 8'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule